// File: doc/BRIEF.md
# Accumulator CPU Core

A small multi-cycle processor with a single 8-bit accumulator. Each instruction is one 16-bit word. The core fetches it from a 256-word unified memory, decodes a 4-bit opcode and executes it. Immediate arithmetic and logic operations combine the accumulator with the instruction's low byte. Absolute operations read or write the memory word that the low byte addresses. Direct jumps load the program counter from the same byte. A zero flag follows the accumulator. Conditional branches test only that flag. There is no carry or overflow flag.

The memory sits outside the core on one single-port bus with a fixed one-cycle read latency. The address driven in cycle N returns its word on `mem_rdata` in cycle N+1. A write takes effect at the end of the cycle in which `mem_we` is high. The bus has no valid/ready handshake and no back-pressure, so the memory must always answer in exactly one cycle. Debug outputs expose the program counter, the accumulator, the instruction register and the zero flag.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high and at the first cycle after it falls, PC, accumulator and instruction register read 0, the zero flag reads 1, and the first fetch drives address 0.
- R2: Instruction fields: opcode in bits [15:12], 8-bit operand in bits [7:0], bits [11:8] ignored. Immediate opcodes: 0000 loads the operand, 0001 adds it, 0010 subtracts it, 0011 ANDs it. Add and subtract wrap modulo 256.
- R3: Memory-operand opcodes 0100 (load), 0110 (add from memory) and 0111 (subtract from memory) use only bits [7:0] of the addressed word. The high byte has no effect on the accumulator.
- R4: Opcode 0101 raises `mem_we` for exactly one cycle, with `mem_addr` equal to the operand and `mem_wdata` equal to {8'h00, accumulator}.
- R5: The zero flag is 1 exactly when the accumulator is 0. Store and the jumps leave both unchanged.
- R6: Opcode 1000 always jumps. 1001 jumps when the zero flag is 1. 1010 jumps when it is 0. A taken jump loads PC with the operand, and a jump that is not taken advances PC by one.
- R7: Every non-jump instruction advances PC by one, and PC wraps from 255 to 0.
- R8: Opcodes 1011 to 1111 only advance PC. Accumulator, flag and memory are untouched.
- R9: Instruction timing: fetch, decode and execute take one cycle each. Load, add-from-memory and subtract-from-memory add one read cycle, so an instruction takes 3 or 4 clocks. The instruction fetch address is PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address (PC or operand) |
| mem_rdata | input | 16 | Read word, valid the cycle after its address |
| mem_wdata | output | 16 | Store data, high byte zero |
| mem_we | output | 1 | Write enable for the current address |
| dbg_pc | output | 8 | Program counter |
| dbg_acc | output | 8 | Accumulator |
| dbg_ir | output | 16 | Instruction register |
| dbg_zero | output | 1 | Zero flag |

## Verification
The hardest state to reach from the ports is the program counter wrapping from 255 to 0 while the flags are in a chosen condition. This has to happen at a point where a conditional jump at address 0 then takes the opposite decision from its first visit. A second program reaches it: the jump at address 0 falls through just after reset, a jump sends execution to address 250, and arithmetic there sets the accumulator nonzero before the last word falls off the top of memory. The first program covers the other corners: wrap-around arithmetic, high bytes of data words that must be ignored, nonzero ignored instruction bits and an undefined opcode. A behavioural model in the bench is compared with the debug and bus outputs on every clock.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam logic [3:0] OPC_MOVE  = 4'h0;
  localparam logic [3:0] OPC_ADD   = 4'h1;
  localparam logic [3:0] OPC_SUB   = 4'h2;
  localparam logic [3:0] OPC_AND   = 4'h3;
  localparam logic [3:0] OPC_LOAD  = 4'h4;
  localparam logic [3:0] OPC_STORE = 4'h5;
  localparam logic [3:0] OPC_ADDM  = 4'h6;
  localparam logic [3:0] OPC_SUBM  = 4'h7;
  localparam logic [3:0] OPC_JMP   = 4'h8;
  localparam logic [3:0] OPC_JZ    = 4'h9;
  localparam logic [3:0] OPC_JNZ   = 4'hA;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_MEMRD  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_AND  = 2'd3
  } alu_op_e;

  function automatic alu_op_e alu_sel(input logic [3:0] opc);
    alu_op_e r;
    case (opc)
      OPC_ADD, OPC_ADDM: r = ALU_ADD;
      OPC_SUB, OPC_SUBM: r = ALU_SUB;
      OPC_AND:           r = ALU_AND;
      default:           r = ALU_PASS;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] res,
  output logic              res_zero
);

  always_comb begin
    case (op)
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = opa - opb;
      ALU_AND: res = opa & opb;
      default: res = opb;
    endcase
  end

  assign res_zero = (res == '0);

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zero,
  output phase_e           phase,
  output logic             ir_load,
  output logic             acc_load,
  output logic             pc_inc,
  output logic             pc_jump,
  output logic             addr_opnd,
  output logic             src_mem,
  output logic             mem_we,
  output alu_op_e          alu_op
);

  phase_e phase_nxt;

  always_ff @(posedge clk) begin
    if (rst) phase <= ST_FETCH;
    else     phase <= phase_nxt;
  end

  always_comb begin
    phase_nxt = phase;
    ir_load   = 1'b0;
    acc_load  = 1'b0;
    pc_inc    = 1'b0;
    pc_jump   = 1'b0;
    addr_opnd = 1'b0;
    src_mem   = 1'b0;
    mem_we    = 1'b0;
    alu_op    = alu_sel(opcode);
    case (phase)
      ST_FETCH: phase_nxt = ST_DECODE;
      ST_DECODE: begin
        ir_load   = 1'b1;
        phase_nxt = ST_EXEC;
      end
      ST_EXEC: begin
        phase_nxt = ST_FETCH;
        case (opcode)
          OPC_MOVE, OPC_ADD, OPC_SUB, OPC_AND: begin
            acc_load = 1'b1;
            pc_inc   = 1'b1;
          end
          OPC_LOAD, OPC_ADDM, OPC_SUBM: begin
            addr_opnd = 1'b1;
            phase_nxt = ST_MEMRD;
          end
          OPC_STORE: begin
            addr_opnd = 1'b1;
            mem_we    = 1'b1;
            pc_inc    = 1'b1;
          end
          OPC_JMP: pc_jump = 1'b1;
          OPC_JZ: begin
            pc_jump = zero;
            pc_inc  = ~zero;
          end
          OPC_JNZ: begin
            pc_jump = ~zero;
            pc_inc  = zero;
          end
          default: pc_inc = 1'b1;
        endcase
      end
      default: begin
        acc_load  = 1'b1;
        src_mem   = 1'b1;
        pc_inc    = 1'b1;
        phase_nxt = ST_FETCH;
      end
    endcase
  end

endmodule

// File: rtl/acc_cpu_state.sv
module acc_cpu_state #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_load,
  input  logic [WORD_W-1:0] ir_in,
  input  logic              acc_load,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              acc_in_zero,
  input  logic              pc_inc,
  input  logic              pc_jump,
  input  logic [ADDR_W-1:0] jump_tgt,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic              zflag,
  output logic [WORD_W-1:0] ir
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (pc_jump) begin
      pc <= jump_tgt;
    end else if (pc_inc) begin
      pc <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      zflag <= 1'b1;
    end else if (acc_load) begin
      acc   <= acc_in;
      zflag <= acc_in_zero;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ir <= '0;
    else if (ir_load) ir <= ir_in;
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_acc,
  output logic [WORD_W-1:0] dbg_ir,
  output logic              dbg_zero
);

  localparam int OPC_W   = 4;
  localparam int OPC_LSB = WORD_W - OPC_W;
  localparam int PAD_W   = WORD_W - DATA_W;

  phase_e            phase;
  alu_op_e           alu_op;
  logic              ir_load, acc_load, pc_inc, pc_jump;
  logic              addr_opnd, src_mem, we_int;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] acc, opb, alu_res;
  logic              alu_zero, zflag;
  logic [WORD_W-1:0] ir;
  logic [OPC_W-1:0]  opcode;
  logic              unused_hi;

  assign opcode = ir[WORD_W-1:OPC_LSB];
  assign opb    = src_mem ? mem_rdata[DATA_W-1:0] : ir[DATA_W-1:0];

  acc_cpu_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .zero      (zflag),
    .phase     (phase),
    .ir_load   (ir_load),
    .acc_load  (acc_load),
    .pc_inc    (pc_inc),
    .pc_jump   (pc_jump),
    .addr_opnd (addr_opnd),
    .src_mem   (src_mem),
    .mem_we    (we_int),
    .alu_op    (alu_op)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .opa      (acc),
    .opb      (opb),
    .op       (alu_op),
    .res      (alu_res),
    .res_zero (alu_zero)
  );

  acc_cpu_state #(.DATA_W(DATA_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_state (
    .clk         (clk),
    .rst         (rst),
    .ir_load     (ir_load),
    .ir_in       (mem_rdata),
    .acc_load    (acc_load),
    .acc_in      (alu_res),
    .acc_in_zero (alu_zero),
    .pc_inc      (pc_inc),
    .pc_jump     (pc_jump),
    .jump_tgt    (ir[ADDR_W-1:0]),
    .pc          (pc),
    .acc         (acc),
    .zflag       (zflag),
    .ir          (ir)
  );

  assign mem_addr = addr_opnd ? ir[ADDR_W-1:0] : pc;
  assign mem_we   = we_int;

  generate
    if (PAD_W > 0) begin : g_pad
      assign mem_wdata = {{PAD_W{1'b0}}, acc};
    end else begin : g_nopad
      assign mem_wdata = acc[WORD_W-1:0];
    end
  endgenerate

  assign unused_hi = ^{mem_rdata[WORD_W-1:DATA_W], ir[OPC_LSB-1:DATA_W], phase};

  assign dbg_pc   = pc;
  assign dbg_acc  = acc;
  assign dbg_ir   = ir;
  assign dbg_zero = zflag;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic [ADDR_W-1:0] dbg_pc,
  input logic [DATA_W-1:0] dbg_acc,
  input logic [WORD_W-1:0] dbg_ir,
  input logic              dbg_zero
);

  p_first_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == '0 && dbg_pc == '0));

  p_zero_tracks_acc_r5: assert property (@(posedge clk) disable iff (rst)
    dbg_zero == (dbg_acc == '0));

  p_store_keeps_acc_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> $stable(dbg_acc));

  p_store_high_zero_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata[WORD_W-1:DATA_W] == '0);

  p_store_low_acc_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata[DATA_W-1:0] == dbg_acc && mem_addr == dbg_ir[ADDR_W-1:0]));

  p_store_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(dbg_pc) |-> (dbg_pc == $past(dbg_pc) + 1'b1 || dbg_pc == dbg_ir[ADDR_W-1:0]));

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .dbg_pc    (dbg_pc),
  .dbg_acc   (dbg_acc),
  .dbg_ir    (dbg_ir),
  .dbg_zero  (dbg_zero)
);

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic [15:0] mem_rdata = 16'h0;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [7:0]  dbg_pc;
  logic [7:0]  dbg_acc;
  logic [15:0] dbg_ir;
  logic        dbg_zero;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  logic [15:0] mem [256];
  logic [15:0] mm  [256];
  logic [7:0]  m_pc, m_acc;
  logic [15:0] m_ir;
  logic        m_z;
  int          m_ph;

  always #2.5 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .dbg_pc    (dbg_pc),
    .dbg_acc   (dbg_acc),
    .dbg_ir    (dbg_ir),
    .dbg_zero  (dbg_zero)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // behavioural reference: one phase counter, architectural state, own memory
  always @(posedge clk) begin
    logic [3:0] op;
    logic [7:0] k;
    if (rst) begin
      m_pc = 8'h0; m_acc = 8'h0; m_ir = 16'h0; m_z = 1'b1; m_ph = 0;
    end else begin
      op = m_ir[15:12];
      k  = m_ir[7:0];
      if (m_ph == 0) m_ph = 1;
      else if (m_ph == 1) begin
        m_ir = mm[m_pc];
        m_ph = 2;
      end else if (m_ph == 2 && (op == 4 || op == 6 || op == 7)) begin
        m_ph = 3;
      end else begin
        if (m_ph == 3) begin
          if (op == 4) m_acc = mm[k][7:0];
          else if (op == 6) m_acc = m_acc + mm[k][7:0];
          else m_acc = m_acc - mm[k][7:0];
          m_z = (m_acc == 0);
          m_pc = m_pc + 1;
        end else begin
          case (op)
            4'h0: begin m_acc = k;         m_z = (m_acc == 0); m_pc = m_pc + 1; end
            4'h1: begin m_acc = m_acc + k; m_z = (m_acc == 0); m_pc = m_pc + 1; end
            4'h2: begin m_acc = m_acc - k; m_z = (m_acc == 0); m_pc = m_pc + 1; end
            4'h3: begin m_acc = m_acc & k; m_z = (m_acc == 0); m_pc = m_pc + 1; end
            4'h5: begin mm[k] = {8'h00, m_acc}; m_pc = m_pc + 1; end
            4'h8: m_pc = k;
            4'h9: m_pc = m_z ? k : m_pc + 1;
            4'hA: m_pc = !m_z ? k : m_pc + 1;
            default: m_pc = m_pc + 1;
          endcase
        end
        m_ph = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R7 pc per cycle", dbg_pc, m_pc);
      chk("R2 acc per cycle", dbg_acc, m_acc);
      chk("R9 ir per cycle", dbg_ir, m_ir);
      chk("R5 zero per cycle", dbg_zero, m_z);
      chk("R4 write enable per cycle", mem_we, (m_ph == 2 && m_ir[15:12] == 4'h5));
      if (m_ph == 2 && m_ir[15:12] == 4'h5) begin
        chk("R4 store address", mem_addr, m_ir[7:0]);
        chk("R4 store data", mem_wdata, {8'h00, m_acc});
      end
      if (m_ph == 0 && !rst) chk("R9 fetch address", mem_addr, m_pc);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      summary();
    end
  end

  task automatic put(input int a, input logic [15:0] w);
    mem[a] = w;
    mm[a]  = w;
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) put(i, 16'hFFFF);
  endtask

  initial begin
    fill();
    // program A
    put(0,  16'h0005);  // move 5
    put(1,  16'h1AFE);  // add 0xFE, bits [11:8] nonzero
    put(2,  16'h2003);  // sub 3 -> 0
    put(3,  16'h9006);  // jz 6 taken
    put(4,  16'h0055);
    put(6,  16'h4080);  // load -> 0x10
    put(7,  16'h6081);  // addm -> 0x00
    put(8,  16'hA020);  // jnz not taken
    put(9,  16'h000F);
    put(10, 16'h303C);  // and -> 0x0C
    put(11, 16'h7082);  // subm -> 0xFF
    put(12, 16'h5090);  // store
    put(13, 16'h9030);  // jz not taken
    put(14, 16'hC123);  // undefined
    put(15, 16'h8010);  // jump 16
    put(16, 16'h4090);  // load 0xFF
    put(17, 16'h1001);  // -> 0
    put(18, 16'h5091);  // store 0
    put(19, 16'h8013);  // trap
    put(8'h80, 16'hAB10);
    put(8'h81, 16'hFFF0);
    put(8'h82, 16'h120D);
    put(8'h90, 16'hBEEF);
    put(8'h91, 16'h1234);
    repeat (3) @(negedge clk);
    chk("R1 reset pc", dbg_pc, 8'h00);
    chk("R1 reset acc", dbg_acc, 8'h00);
    chk("R1 reset ir", dbg_ir, 16'h0000);
    chk("R1 reset zero", dbg_zero, 1'b1);
    chk("R1 reset no write", mem_we, 1'b0);
    cmp_on = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first fetch address", mem_addr, 8'h00);
    repeat (150) @(negedge clk);
    chk("R4 store writes zero high byte", mem[8'h90], 16'h00FF);
    chk("R4 store of zero accumulator", mem[8'h91], 16'h0000);
    chk("R3 data word untouched", mem[8'h80], 16'hAB10);
    chk("R2 final accumulator", dbg_acc, 8'h00);
    chk("R5 zero after wrap add", dbg_zero, 1'b1);
    chk("R6 trap jump holds pc", dbg_pc, 8'd19);
    chk("R8 fill word untouched", mem[5], 16'hFFFF);

    // program B: wrap of PC past 255
    rst = 1'b1;
    fill();
    put(0,   16'hA005);  // jnz 5: falls through first, taken after wrap
    put(1,   16'h80FA);  // jump 250
    put(250, 16'h0007);
    put(251, 16'hF0FF);  // undefined
    put(252, 16'h1001);
    put(253, 16'h2008);  // -> 0
    put(254, 16'h90FF);  // jz 255 taken
    put(255, 16'h1021);  // -> 0x21, pc wraps
    put(5,   16'h5064);  // store 100
    put(6,   16'h8006);
    repeat (2) @(negedge clk);
    chk("R1 reset pc again", dbg_pc, 8'h00);
    rst = 1'b0;
    repeat (150) @(negedge clk);
    chk("R7 pc wrap then store", mem[100], 16'h0021);
    chk("R8 undefined opcode kept accumulator", dbg_acc, 8'h21);
    chk("R6 jnz taken after wrap", dbg_pc, 8'd6);
    chk("R5 zero clear", dbg_zero, 1'b0);
    done = 1'b1;
    summary();
  end

endmodule